// File: doc/BRIEF.md
# Transmit Robbed-Bit Signaling Inserter

This block places per-channel signaling bits into a serial 24-channel T1 transmit stream. A host fills a bank of twelve 8-bit registers through a byte-wide write port. Each register carries one signaling bit type for eight channels. At each multiframe boundary the block copies the bank into an internal shadow copy. While the insert enable is high, it then overwrites the least significant bit of every channel slot in the signaling frames with the matching shadow bit. All other bits pass through with one cycle of delay.

Two framing formats are selected by a mode input. The extended superframe format has 24 frames and four bits per channel, and it reloads at every boundary. The superframe format has 12 frames and two bits per channel. One load serves two superframes in a row: the third and fourth register groups act as the first and second bits in the second superframe, so the bank is reloaded only at every other boundary. A sticky flag tells the host that a load has happened, which leaves the host one whole multiframe to write the next values.

Top module: `tx_sig_inserter`

## Requirements
- R1: After reset, `tx_out` and `mf_flag` are 0, every register is 0, and no insertion occurs until the first multiframe boundary.
- R2: Register k (address k, 0..11) holds bit type k/3 (0 = A, 1 = B, 2 = A/C, 3 = B/D) for channels 8*(k%3)+1 to 8*(k%3)+8. Bit i holds the lowest of those channels plus i. Writes to addresses 12..15 change nothing.
- R3: A boundary is a cycle with both `frame_start` and `mf_start` high. The shadow copy changes only at a boundary, so a register write during a multiframe has no effect on the bits sent in that multiframe.
- R4: With `esf_mode` = 1, every boundary loads the shadow. The channel LSB in frames 6, 12, 18 and 24 carries A, B, C and D.
- R5: With `esf_mode` = 0, the channel LSB in frames 6 and 12 carries A and B. The first boundary after reset or after extended-mode operation loads. The next one does not load, and in that multiframe the A/C and B/D bits are sent as A and B. Loads then continue at every other boundary.
- R6: `mf_flag` goes to 1 on every load and stays at 1 until a cycle with `flag_ack` high. A load in the same cycle as `flag_ack` leaves the flag at 1.
- R7: With `ins_en` = 0, `tx_out` equals `tx_in` delayed by one cycle.
- R8: `frame_start` marks the framing bit at position 0. Positions 1..192 carry channels 1..24, eight bits each with the MSB first, so the LSB is the last bit of each slot. Only LSBs in signaling frames are replaced, and each output bit appears one cycle after its input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Register write data |
| flag_ack | input | 1 | Clears the multiframe flag |
| esf_mode | input | 1 | 1 = 24-frame four-bit format, 0 = 12-frame two-bit format |
| ins_en | input | 1 | Signaling insert enable |
| frame_start | input | 1 | Framing-bit position of each frame |
| mf_start | input | 1 | With frame_start, first frame of a multiframe |
| tx_in | input | 1 | Serial transmit data in |
| tx_out | output | 1 | Serial transmit data out, one cycle later |
| mf_flag | output | 1 | Sticky multiframe-load flag |

## Verification
A shadow copy that loads at the wrong time shows up in the first signaling frame after that load. That frame is frame 6, about a thousand bit times into the multiframe, and every channel whose new register value differs from the old one carries the error. A wrong superframe phase swaps the A/B bits with the C/D bits for a whole multiframe, and the flag stays set or clear at the check early in frame 1. Slot-counter errors corrupt data bits that are not LSBs, or LSBs outside frames 6/12/18/24, within the first signaling frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int SLOT_BITS = 8;
   localparam int KINDS     = 4;
   localparam int SIG_STEP  = 6;
   typedef enum logic [1:0] {
      KIND_A  = 2'd0,
      KIND_B  = 2'd1,
      KIND_AC = 2'd2,
      KIND_BD = 2'd3
   } sig_kind_e;
endpackage

// File: rtl/tsi_regbank.sv
module tsi_regbank
   import tsi_pkg::*;
#(
   parameter int CHANNELS = 24,
   parameter int REG_W    = 8,
   parameter int ADDR_W   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [REG_W-1:0]              wdata,
   output logic [KINDS-1:0][CHANNELS-1:0] bits
);
   localparam int GRP   = CHANNELS / REG_W;
   localparam int NREGS = KINDS * GRP;

   logic [REG_W-1:0] regs [NREGS];

   generate
      if (CHANNELS % REG_W != 0) begin : g_bad_ch
         $error("CHANNELS must be a multiple of REG_W");
      end
      if ((1 << ADDR_W) < NREGS) begin : g_bad_addr
         $error("ADDR_W too narrow for register count");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we && (32'(addr) < NREGS)) begin
         regs[addr] <= wdata;
      end
   end

   for (genvar kd = 0; kd < KINDS; kd++) begin : g_kind
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         assign bits[kd][c] = regs[kd*GRP + c/REG_W][c%REG_W];
      end
   end

   assert_oob_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (32'(addr) >= NREGS)) |=> $stable(bits));
endmodule

// File: rtl/tsi_timer.sv
module tsi_timer
   import tsi_pkg::*;
#(
   parameter int CHANNELS = 24,
   parameter int FRM_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frame_start,
   input  logic                        mf_start,
   output logic                        slot_lsb,
   output logic [$clog2(CHANNELS+1)-1:0] chan,
   output logic [FRM_W-1:0]            frame_num
);
   localparam int CH_W  = $clog2(CHANNELS + 1);
   localparam int BIT_W = $clog2(SLOT_BITS);
   localparam logic [CH_W-1:0]  CH_IDLE  = CH_W'(CHANNELS);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);
   localparam logic [FRM_W-1:0] FRM_MAX  = '1;

   logic [BIT_W-1:0] bit_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_pos   <= '0;
         chan      <= CH_IDLE;
         frame_num <= '0;
      end else if (frame_start) begin
         bit_pos   <= '0;
         chan      <= '0;
         if (mf_start)                frame_num <= FRM_W'(1);
         else if (frame_num != FRM_MAX) frame_num <= frame_num + 1'b1;
      end else if (chan != CH_IDLE) begin
         if (bit_pos == BIT_LAST) begin
            bit_pos <= '0;
            chan    <= chan + 1'b1;
         end else begin
            bit_pos <= bit_pos + 1'b1;
         end
      end
   end

   assign slot_lsb = !frame_start && (chan != CH_IDLE) && (bit_pos == BIT_LAST);

   assert_frame_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (chan == '0 && !slot_lsb));
endmodule

// File: rtl/tsi_shadow.sv
module tsi_shadow
   import tsi_pkg::*;
#(
   parameter int CHANNELS = 24
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           boundary,
   input  logic                           esf_mode,
   input  logic                           flag_ack,
   input  logic [KINDS-1:0][CHANNELS-1:0] reg_bits,
   output logic [KINDS-1:0][CHANNELS-1:0] shadow,
   output logic                           cd_half,
   output logic                           mf_flag
);
   logic load;
   assign load = boundary && (esf_mode || cd_half);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow  <= '0;
         cd_half <= 1'b1;
         mf_flag <= 1'b0;
      end else begin
         if (load) shadow <= reg_bits;
         if (boundary) cd_half <= esf_mode ? 1'b1 : !cd_half;
         if (load)          mf_flag <= 1'b1;
         else if (flag_ack) mf_flag <= 1'b0;
      end
   end

   assert_hold_between_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(shadow));
   assert_esf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && esf_mode) |=> mf_flag);
   assert_d4_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !esf_mode && !cd_half) |=> ($stable(shadow) && cd_half));
   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_flag && !flag_ack) |=> mf_flag);
endmodule

// File: rtl/tx_sig_inserter.sv
module tx_sig_inserter
   import tsi_pkg::*;
#(
   parameter int CHANNELS = 24,
   parameter int REG_W    = 8,
   parameter int ADDR_W   = 4,
   parameter int FRM_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [REG_W-1:0]  host_wdata,
   input  logic              flag_ack,
   input  logic              esf_mode,
   input  logic              ins_en,
   input  logic              frame_start,
   input  logic              mf_start,
   input  logic              tx_in,
   output logic              tx_out,
   output logic              mf_flag
);
   localparam int CH_W = $clog2(CHANNELS + 1);

   logic [KINDS-1:0][CHANNELS-1:0] reg_bits;
   logic [KINDS-1:0][CHANNELS-1:0] shadow;
   logic                           cd_half;
   logic                           slot_lsb;
   logic [CH_W-1:0]                chan;
   logic [FRM_W-1:0]               frame_num;
   logic                           sig_frame;
   sig_kind_e                      kind;
   logic                           ins;

   tsi_regbank #(.CHANNELS(CHANNELS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
      .wdata(host_wdata), .bits(reg_bits)
   );

   tsi_timer #(.CHANNELS(CHANNELS), .FRM_W(FRM_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_start(mf_start),
      .slot_lsb(slot_lsb), .chan(chan), .frame_num(frame_num)
   );

   tsi_shadow #(.CHANNELS(CHANNELS)) u_shadow (
      .clk(clk), .rst_n(rst_n), .boundary(frame_start && mf_start),
      .esf_mode(esf_mode), .flag_ack(flag_ack), .reg_bits(reg_bits),
      .shadow(shadow), .cd_half(cd_half), .mf_flag(mf_flag)
   );

   always_comb begin
      sig_frame = 1'b1;
      kind      = KIND_A;
      case (frame_num)
         FRM_W'(SIG_STEP):   kind = (!esf_mode && cd_half) ? KIND_AC : KIND_A;
         FRM_W'(2*SIG_STEP): kind = (!esf_mode && cd_half) ? KIND_BD : KIND_B;
         FRM_W'(3*SIG_STEP): begin kind = KIND_AC; sig_frame = esf_mode; end
         FRM_W'(4*SIG_STEP): begin kind = KIND_BD; sig_frame = esf_mode; end
         default:            sig_frame = 1'b0;
      endcase
   end

   assign ins = ins_en && slot_lsb && sig_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) tx_out <= 1'b0;
      else        tx_out <= ins ? shadow[kind][chan] : tx_in;
   end

   assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_en |=> (tx_out == $past(tx_in)));
   assert_lsb_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_lsb |=> (tx_out == $past(tx_in)));
endmodule

// File: tb/tx_sig_inserter_test.sv
module tx_sig_inserter_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic flag_ack = 1'b0, esf_mode = 1'b1, ins_en = 1'b0;
   logic frame_start = 1'b0, mf_start = 1'b0, tx_in = 1'b0;
   logic tx_out, mf_flag;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [7:0] mirror [12];
   logic       snap [4][24];
   bit         cd = 1;
   bit         bflag = 0;

   // {addr, data}; addresses 12..15 must be ignored (R2)
   localparam logic [11:0] WTAB [16] = '{
      12'h0_A5, 12'h1_3C, 12'h2_F0, 12'h3_5A, 12'h4_0F, 12'h5_C3,
      12'h6_96, 12'h7_E1, 12'h8_1E, 12'h9_69, 12'hA_87, 12'hB_D2,
      12'hC_FF, 12'hD_FF, 12'hE_FF, 12'hF_FF };

   always #4 clk = ~clk;

   tx_sig_inserter uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .flag_ack(flag_ack), .esf_mode(esf_mode),
      .ins_en(ins_en), .frame_start(frame_start), .mf_start(mf_start),
      .tx_in(tx_in), .tx_out(tx_out), .mf_flag(mf_flag)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit fs, input bit ms, input bit din, input bit exp,
                       input bit we, input logic [3:0] a, input logic [7:0] d,
                       input bit ack, input string tag);
      frame_start = fs; mf_start = ms; tx_in = din;
      host_we = we; host_addr = a; host_wdata = d; flag_ack = ack;
      @(posedge clk);
      @(negedge clk);
      host_we = 1'b0; flag_ack = 1'b0;
      chk(tx_out, exp, tag);
   endtask

   function automatic bit pat(int f, int p);
      return ((p * 7 + f * 3) % 5) < 2;
   endfunction

   task automatic run_mf(input bit esf, input bit en, input logic [3:0] wa,
                         input logic [7:0] wd, input bit ack_at_bound);
      int nfr = esf ? 24 : 12;
      bit ld = esf || cd;
      esf_mode = esf; ins_en = en;
      if (ld) begin
         for (int k = 0; k < 4; k++)
            for (int c = 0; c < 24; c++) snap[k][c] = mirror[k*3 + c/8][c%8];
         bflag = 1;
      end else if (ack_at_bound) bflag = 0;
      cd = esf ? 1 : !cd;
      for (int f = 1; f <= nfr; f++) begin
         for (int p = 0; p < 193; p++) begin
            bit din = pat(f, p);
            bit ex = din;
            bit we = (f == 3 && p == 10);
            bit ack = (f == 2 && p == 100) || (ack_at_bound && f == 1 && p == 0);
            string tag = "R8";
            if (!en) tag = "R7";
            if (en && p > 0 && ((p - 1) % 8) == 7 && (f % 6) == 0) begin
               int ch = (p - 1) / 8;
               int kd = -1;
               if (esf) kd = f / 6 - 1;
               else if (f == 6) kd = cd ? 2 : 0;
               else if (f == 12) kd = cd ? 3 : 1;
               if (kd >= 0) begin
                  ex = snap[kd][ch];
                  tag = esf ? "R4" : "R5";
               end
            end
            step(p == 0, p == 0 && f == 1, din, ex, we, wa, wd, ack, tag);
            if (we && wa < 12) mirror[wa] = wd;  // mid-frame write, R3
            if (f == 1 && p == 5) chk(mf_flag, bflag, "R6 flag after boundary");
            if (f == 2 && p == 100) bflag = 0;
            if (f == 2 && p == 120) chk(mf_flag, bflag, "R6 flag after ack");
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 12; i++) mirror[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(tx_out, 1'b0, "R1 tx_out");
      chk(mf_flag, 1'b0, "R1 mf_flag");
      // R1: no insertion before first boundary, even with enable
      ins_en = 1'b1;
      for (int i = 0; i < 20; i++) step(0, 0, pat(0, i), pat(0, i), 0, 0, 0, 0, "R1 idle");
      // table of register writes, R2
      for (int i = 0; i < 16; i++) begin
         logic [3:0] a = WTAB[i][11:8];
         logic [7:0] d = WTAB[i][7:0];
         step(0, 0, pat(1, i), pat(1, i), 1, a, d, 0, "R2 write");
         if (a < 12) mirror[a] = d;
      end
      // R4: extended format, two loads; mid-frame writes land next time (R3)
      run_mf(1, 1, 4'd0, 8'h3B, 0);
      run_mf(1, 1, 4'd7, 8'h4D, 0);
      // R5: superframe format: load, C/D reuse, load (ack with load, R6)
      run_mf(0, 1, 4'd9, 8'h77, 0);
      run_mf(0, 1, 4'd1, 8'hB4, 0);
      run_mf(0, 1, 4'd10, 8'h2E, 1);
      // R7: insertion disabled, data untouched
      run_mf(1, 0, 4'd2, 8'h11, 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule